// File: doc/BRIEF.md
# Serial Register-Access Port

This block is the device-side serial port of a measurement converter. A host drives chip select, a serial clock and a data input. The port answers on a single data output that also carries the ready flag. Each access opens with an 8-bit command byte. The command chooses a read or a write and one of four register slots. The port then shifts the chosen register in or out, and afterwards waits for the next command byte. The conversion engine sits outside the block. It presents each new 24-bit result together with a one-cycle strobe, and it receives the mode byte, the filter byte, the channel field and a restart pulse.

The serial pins are brought into the fast system clock through synchronizer flops, and serial clock edges are detected there. There is also a sticky streaming mode, in which every fresh result is shifted out without any command. A run of ones on the data input returns the whole interface to its power-on state.

Top module: `ser_reg_port`

## Requirements
- R1: After reset, reading the status slot returns 0x8C, `mode_reg` is 0x02 and `filt_reg` is 0x04. The status byte is {not-ready, 0, 0, 0, 1, 1, channel[1:0]}.
- R2: Command bits are sampled on serial clock rising edges, MSB first. While no command bit has been taken, a 1 on the data input is discarded, and the command starts at the first 0.
- R3: The command byte is laid out as bit7 start (0), bit6 (0), bits5:4 select, bit3 read (1) or write (0), bit2 streaming, bits1:0 channel. Select 00 reads the status byte, 01 the mode byte, 10 the filter byte and 11 the 24-bit result. Data moves MSB first.
- R4: Writing select 01 or 10 takes the next 8 bits into `mode_reg` or `filt_reg` and raises `restart` for exactly one system cycle.
- R5: During a transfer the output bit changes only after a serial clock falling edge, so it is steady across each rising edge.
- R6: With chip select low and no transfer running, `sdo` shows the inverted ready flag. Ready is set by `res_strobe`.
- R7: Completing a 24-bit result read clears ready, which drives `sdo` high. Outside streaming mode the result can be read again and returns the same value.
- R8: Command 0b001111xx enters streaming mode. In that mode each new result is shifted out on the following serial clocks with no command, and only once. With ready clear, `sdo` stays high.
- R9: In streaming mode, other command bytes have no effect. Command 0b001110xx leaves the mode only when it completes while ready is set.
- R10: 32 consecutive ones on the data input, counted on rising edges, restore every register, clear streaming mode and return the port to waiting for a command. 31 ones do not do this.
- R11: With chip select high, `sdo_oe` is low. Raising chip select abandons a partial access, and register contents are kept.
- R12: The channel bits of every accepted command appear in the status byte and on `chan_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host, idles high |
| sdi | input | 1 | Serial data from the host |
| res_data | input | DATA_W | Latest conversion result |
| res_strobe | input | 1 | One-cycle pulse: new result available |
| sdo | output | 1 | Serial data out / inverted ready |
| sdo_oe | output | 1 | Output enable for the pad driver |
| mode_reg | output | 8 | Mode byte for the conversion engine |
| filt_reg | output | 8 | Filter byte for the conversion engine |
| chan_sel | output | 2 | Channel field of the last command |
| restart | output | 1 | Pulse after a mode or filter write |

## Verification
The hardest case to reach is a streaming-mode exit command whose last bit arrives while a result is being shifted out. That is the only moment when ready is set and the exit can take effect. The stimulus delivers a result first and then sends the exit byte as the first eight bits of that same 24-bit shift. The returned word proves that streaming stayed active until then, and a later result that does not appear on its own proves that the mode was left. The 31/32 boundary of the ones counter is approached the same way, with command bytes chosen so that no ones leak in from the neighbouring bytes.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {ST_CMD, ST_WR, ST_RD} port_st_t;

  localparam logic [1:0] SEL_CTRL = 2'b00;
  localparam logic [1:0] SEL_MODE = 2'b01;
  localparam logic [1:0] SEL_FILT = 2'b10;
  localparam logic [1:0] SEL_DATA = 2'b11;

  localparam logic [REG_W-1:0] MODE_RST = 8'h02;
  localparam logic [REG_W-1:0] FILT_RST = 8'h04;

  // status: not-ready, two zero bits, 0, two fixed ones, channel
  function automatic logic [REG_W-1:0] status_byte(input logic avail, input logic [1:0] ch);
    return {~avail, 3'b000, 2'b11, ch};
  endfunction

  function automatic logic [1:0] cmd_sel(input logic [REG_W-1:0] b);
    return b[5:4];
  endfunction

  function automatic logic cmd_is_read(input logic [REG_W-1:0] b);
    return b[3];
  endfunction

  function automatic logic cmd_stream_on(input logic [REG_W-1:0] b);
    return b[7:2] == 6'b001111;
  endfunction

  function automatic logic cmd_stream_off(input logic [REG_W-1:0] b);
    return b[7:2] == 6'b001110;
  endfunction
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int STAGES = 2,
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= d_in;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srp_ones.sv
module srp_ones #(
  parameter int RUN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic bit_in,
  output logic hit
);
  localparam int CW = $clog2(RUN + 1);
  logic [CW-1:0] run_q;

  assign hit = step & bit_in & (run_q == CW'(RUN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (clr || hit) run_q <= '0;
    else if (step) run_q <= bit_in ? run_q + 1'b1 : '0;
  end

  p_run_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < CW'(RUN));
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
  import srp_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int SYNC_STAGES = 2,
  parameter int RESYNC_ONES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_strobe,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [REG_W-1:0]  mode_reg,
  output logic [REG_W-1:0]  filt_reg,
  output logic [1:0]        chan_sel,
  output logic              restart
);
  localparam int TCW = $clog2(DATA_W);
  localparam int BCW = $clog2(REG_W);
  localparam int PAD = DATA_W - REG_W;

  // synchronised pins: {cs_n, sclk, sdi}
  logic [2:0] pins_s;
  logic cs_s, sclk_s, sdi_s, sclk_d;

  srp_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in({cs_n, sclk, sdi}), .q(pins_s));

  assign {cs_s, sclk_s, sdi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b1;
    else sclk_d <= sclk_s;
  end

  // named events
  wire rise_ev = sclk_s & ~sclk_d & ~cs_s;
  wire fall_ev = ~sclk_s & sclk_d & ~cs_s;
  logic ones_hit;

  srp_ones #(.RUN(RESYNC_ONES)) u_ones (
    .clk(clk), .rst_n(rst_n), .clr(cs_s), .step(rise_ev), .bit_in(sdi_s), .hit(ones_hit));

  port_st_t st;
  logic [BCW-1:0] bit_cnt;
  logic [REG_W-2:0] cmd_sr;
  logic [REG_W-1:0] rx_sr;
  logic [1:0] wsel_q;
  logic [DATA_W-1:0] tx_sr;
  logic [TCW-1:0] tx_cnt, tx_last;
  logic tx_active, tx_is_data, sdo_q, avail_q, stream_q;
  logic [REG_W-1:0] mode_q, filt_q;
  logic [1:0] chan_q;
  logic restart_q;

  wire [REG_W-1:0] cmd_byte = {cmd_sr, sdi_s};
  wire cmd_done   = rise_ev && !ones_hit && st == ST_CMD && bit_cnt == BCW'(REG_W-1);
  wire wr_done    = rise_ev && !ones_hit && st == ST_WR  && bit_cnt == BCW'(REG_W-1);
  wire tx_done    = rise_ev && !ones_hit && tx_active && tx_cnt == tx_last;
  wire data_done  = tx_done && tx_is_data;
  wire strm_start = fall_ev && !ones_hit && !tx_active && stream_q && avail_q;
  wire wen_skip   = rise_ev && st == ST_CMD && bit_cnt == '0 && sdi_s;

  // value loaded for a register read
  logic [DATA_W-1:0] rd_val;
  always_comb begin
    case (cmd_sel(cmd_byte))
      SEL_CTRL: rd_val = {status_byte(avail_q, cmd_byte[1:0]), PAD'(0)};
      SEL_MODE: rd_val = {mode_q, PAD'(0)};
      SEL_FILT: rd_val = {filt_q, PAD'(0)};
      default:  rd_val = res_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) avail_q <= 1'b0;
    else avail_q <= res_strobe | (avail_q & ~ones_hit & ~data_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_CMD; bit_cnt <= '0; cmd_sr <= '0; rx_sr <= '0; wsel_q <= SEL_CTRL;
      tx_sr <= '0; tx_cnt <= '0; tx_last <= '0; tx_active <= 1'b0; tx_is_data <= 1'b0;
      sdo_q <= 1'b1; stream_q <= 1'b0; mode_q <= MODE_RST; filt_q <= FILT_RST;
      chan_q <= 2'b00; restart_q <= 1'b0;
    end else begin
      restart_q <= 1'b0;
      if (ones_hit) begin
        st <= ST_CMD; bit_cnt <= '0; tx_active <= 1'b0; stream_q <= 1'b0;
        mode_q <= MODE_RST; filt_q <= FILT_RST; chan_q <= 2'b00;
      end else if (cs_s) begin
        st <= ST_CMD; bit_cnt <= '0; tx_active <= 1'b0;
      end else if (rise_ev) begin
        if (tx_active) begin
          tx_cnt <= tx_cnt + 1'b1;
          if (tx_done) begin
            tx_active <= 1'b0;
            if (st == ST_RD) st <= ST_CMD;
          end
        end
        case (st)
          ST_CMD: begin
            if (!wen_skip) begin
              cmd_sr <= {cmd_sr[REG_W-3:0], sdi_s};
              bit_cnt <= bit_cnt + 1'b1;
            end
            if (cmd_done) begin
              bit_cnt <= '0;
              if (stream_q) begin
                if (cmd_stream_off(cmd_byte) && avail_q) stream_q <= 1'b0;
              end else begin
                chan_q <= cmd_byte[1:0];
                if (cmd_is_read(cmd_byte)) begin
                  if (cmd_stream_on(cmd_byte)) stream_q <= 1'b1;
                  else begin
                    st <= ST_RD; tx_sr <= rd_val; tx_cnt <= '0; tx_active <= 1'b1;
                    tx_is_data <= cmd_sel(cmd_byte) == SEL_DATA;
                    tx_last <= (cmd_sel(cmd_byte) == SEL_DATA) ? TCW'(DATA_W-1) : TCW'(REG_W-1);
                  end
                end else if (cmd_sel(cmd_byte) == SEL_MODE || cmd_sel(cmd_byte) == SEL_FILT) begin
                  st <= ST_WR; wsel_q <= cmd_sel(cmd_byte);
                end
              end
            end
          end
          ST_WR: begin
            rx_sr <= {rx_sr[REG_W-2:0], sdi_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (wr_done) begin
              bit_cnt <= '0; st <= ST_CMD; restart_q <= 1'b1;
              if (wsel_q == SEL_MODE) mode_q <= {rx_sr[REG_W-2:0], sdi_s};
              else filt_q <= {rx_sr[REG_W-2:0], sdi_s};
            end
          end
          default: ;
        endcase
      end else if (fall_ev) begin
        if (tx_active) begin
          sdo_q <= tx_sr[DATA_W-1];
          tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
        end else if (strm_start) begin
          sdo_q <= res_data[DATA_W-1];
          tx_sr <= {res_data[DATA_W-2:0], 1'b0};
          tx_active <= 1'b1; tx_is_data <= 1'b1; tx_cnt <= '0; tx_last <= TCW'(DATA_W-1);
        end
      end
    end
  end

  assign sdo      = tx_active ? sdo_q : ~avail_q;
  assign sdo_oe   = ~cs_s;
  assign mode_reg = mode_q;
  assign filt_reg = filt_q;
  assign chan_sel = chan_q;
  assign restart  = restart_q;

  p_wen_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wen_skip && !ones_hit |=> bit_cnt == '0 && st == ST_CMD);
  p_restart_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart_q |=> !restart_q);
  p_out_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_ev |=> $stable(sdo_q));
  p_ready_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_done && !res_strobe |=> !avail_q);
  p_ones_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ones_hit |=> mode_q == MODE_RST && filt_q == FILT_RST && !stream_q && st == ST_CMD);
  p_cs_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> st == ST_CMD && !tx_active);
endmodule

// File: tb/ser_reg_port_bench.sv
module ser_reg_port_bench;
  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, sdi, res_strobe;
  logic [23:0] res_data;
  logic sdo, sdo_oe, restart;
  logic [7:0] mode_reg, filt_reg;
  logic [1:0] chan_sel;
  int n_chk = 0, n_fail = 0, n_rst = 0, mism = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ser_reg_port u_ser_reg_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .res_data(res_data), .res_strobe(res_strobe), .sdo(sdo), .sdo_oe(sdo_oe),
    .mode_reg(mode_reg), .filt_reg(filt_reg), .chan_sel(chan_sel), .restart(restart));

  always @(posedge clk) if (restart) n_rst++;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // n bits MSB first; sample sdo before each rise, and again before the next fall
  task automatic xfer(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0; sdi = din[i]; wt(8);
      dout[i] = sdo;
      sclk = 1'b1; wt(8);
      if (i > 0 && sdo !== dout[i]) mism++;
    end
  endtask

  task automatic give(input logic [23:0] d);
    @(negedge clk); res_data = d; res_strobe = 1'b1;
    @(negedge clk); res_strobe = 1'b0; wt(2);
  endtask

  function automatic logic [7:0] exp_status(input bit av, input int ch);
    return 8'(((av ? 0 : 1) * 128) + 12 + ch);
  endfunction

  initial begin
    logic [31:0] d;
    rst_n = 0; cs_n = 1; sclk = 1; sdi = 0; res_strobe = 0; res_data = '0;
    wt(5); rst_n = 1; wt(5);
    chk("R11 oe low while deselected", 32'(sdo_oe), 0);
    chk("R1 mode reset", 32'(mode_reg), 32'h02);
    chk("R1 filter reset", 32'(filt_reg), 32'h04);
    cs_n = 0; wt(8);
    chk("R11 oe high when selected", 32'(sdo_oe), 1);
    xfer(8, 32'h08, d); xfer(8, 0, d);
    chk("R1 status reset", d, 32'h8C);
    chk("R6 idle pin not ready", 32'(sdo), 1);
    give(24'hA5C396);
    chk("R6 idle pin ready", 32'(sdo), 0);
    xfer(8, 32'h38, d); xfer(24, 0, d);
    chk("R3 data read", d, 32'hA5C396);
    chk("R7 pin high after read", 32'(sdo), 1);
    xfer(8, 32'h38, d); xfer(24, 0, d);
    chk("R7 re-read", d, 32'hA5C396);
    // R2: leading ones ignored before the command
    xfer(5, 32'h1F, d); xfer(8, 32'h20, d); xfer(8, 32'h07, d);
    chk("R2 filter after leading ones", 32'(filt_reg), 32'h07);
    chk("R4 one restart pulse", n_rst, 1);
    xfer(8, 32'h10, d); xfer(8, 32'h82, d);
    chk("R4 mode written", 32'(mode_reg), 32'h82);
    chk("R4 second restart pulse", n_rst, 2);
    xfer(8, 32'h18, d); xfer(8, 0, d);
    chk("R3 mode read", d, 32'h82);
    xfer(8, 32'h28, d); xfer(8, 0, d);
    chk("R3 filter read", d, 32'h07);
    // R12: channel sweep with both ready states
    for (int av = 0; av < 2; av++) begin
      if (av == 1) give(24'h123456);
      for (int ch = 0; ch < 4; ch++) begin
        xfer(8, 32'(8 + ch), d); xfer(8, 0, d);
        chk("R12 status channel", d, 32'(exp_status(av == 1, ch)));
        chk("R12 chan_sel", 32'(chan_sel), 32'(ch));
      end
      if (av == 1) begin xfer(8, 32'h38, d); xfer(24, 0, d); end
    end
    // R11: abandon a mode write part way
    xfer(8, 32'h10, d); xfer(4, 32'hF, d);
    cs_n = 1; wt(8); cs_n = 0; wt(8);
    xfer(8, 32'h18, d); xfer(8, 0, d);
    chk("R11 mode kept after abort", d, 32'h82);
    chk("R5 pin steady across rising edges", mism, 0);
    // R8 streaming
    xfer(8, 32'h3C, d);
    give(24'h5E1F0A);
    xfer(24, 0, d);
    chk("R8 streamed result", d, 32'h5E1F0A);
    chk("R8 pin high after stream", 32'(sdo), 1);
    xfer(24, 0, d);
    chk("R8 no second copy", d, 32'hFFFFFF);
    give(24'h0C0FFE);
    xfer(24, 0, d);
    chk("R8 next result streamed", d, 32'h0C0FFE);
    // R9 exit rules
    xfer(8, 32'h38, d);
    give(24'h9ABCDE);
    xfer(24, 32'h380000, d);
    chk("R9 stream survived early exit", d, 32'h9ABCDE);
    give(24'h7E5A3C);
    xfer(24, 0, d);
    chk("R9 stream left", d, 32'h0);
    xfer(8, 32'h38, d); xfer(24, 0, d);
    chk("R9 normal read after exit", d, 32'h7E5A3C);
    // R10 ones resync
    xfer(8, 32'h10, d); xfer(8, 32'h86, d);
    xfer(31, 32'h7FFFFFFF, d);
    xfer(8, 32'h18, d); xfer(8, 0, d);
    chk("R10 31 ones keep state", d, 32'h86);
    xfer(8, 32'h3C, d);
    xfer(32, 32'hFFFFFFFF, d);
    chk("R10 mode restored", 32'(mode_reg), 32'h02);
    chk("R10 filter restored", 32'(filt_reg), 32'h04);
    xfer(8, 32'h08, d); xfer(8, 0, d);
    chk("R10 status restored", d, 32'h8C);
    give(24'h3355AA);
    xfer(24, 0, d);
    chk("R10 stream cleared", d, 32'h0);
    xfer(8, 32'h38, d); xfer(24, 0, d);
    chk("R10 read after resync", d, 32'h3355AA);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule